// File: doc/BRIEF.md
# Streaming Receive Buffer with Late-Beat Allowance

This block terminates a valid/ready stream and buffers the beats it receives. The sender is permitted to keep pushing a bounded number of beats after the receiver has lowered its ready signal. The block therefore lowers ready while it still has that many spare entries. Every permitted late beat lands in storage and none is lost. The late beats need not come in consecutive cycles: valid may go high and low freely while ready is low, and each valid beat uses up one unit of the allowance.

On the output side the buffered beats leave in arrival order over a zero-latency valid/ready port. A beat moves on any cycle where both valid and ready are high. A sender that pushes more late beats than the allowance permits is caught: the extra beat is discarded and a sticky overflow flag goes high. The allowance, the ready latency it defaults to, the data width and the buffer depth are elaboration-time parameters.

Top module: `stream_skid_sink`

## Requirements
- R1: After reset the buffer is empty (`dn_valid` low), `up_ready` is high and `overflow` is low.
- R2: Accepted beats leave on `dn_data` in the order they arrived. `dn_valid` is high exactly when at least one beat is stored, and `dn_data` then shows the oldest stored beat.
- R3: `up_ready` is high in a cycle exactly when the free entries (DEPTH minus the occupancy in that cycle) number at least ALLOWANCE+1. It follows each occupancy change one clock later. With the defaults (DEPTH 8, allowance 2) it is high while occupancy is at most 5.
- R4: While `up_ready` is low, up to ALLOWANCE beats with `up_valid` high are still accepted and stored, whether they come back to back or with idle cycles between them.
- R5: The count of late beats is cleared whenever `up_ready` rises, so each low period of `up_ready` grants the full allowance again.
- R6: A beat with `up_valid` high while `up_ready` is low and the allowance is already used up is discarded. `overflow` goes high on the next cycle and stays high until reset.
- R7: A beat accepted and a beat delivered in the same cycle leave the occupancy unchanged.
- R8: A beat leaves only in a cycle with `dn_valid` and `dn_ready` both high. While `dn_valid` is high and `dn_ready` is low, `dn_data` holds its value.
- R9: When ALLOWANCE is not given, it takes the value of LATENCY. With the default LATENCY of 2, two late beats are accepted and a third is flagged.
- R10: With ALLOWANCE set to 0, any beat with `up_valid` high while `up_ready` is low is discarded and sets `overflow`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up_data | input | DATA_W | Incoming beat data |
| up_valid | input | 1 | Incoming beat present |
| up_ready | output | 1 | Receiver ready toward the sender |
| dn_data | output | DATA_W | Oldest stored beat |
| dn_valid | output | 1 | A stored beat is available |
| dn_ready | input | 1 | Consumer takes the beat this cycle |
| overflow | output | 1 | Sticky flag: a beat beyond the allowance arrived |

## Verification
Two things can land in the same cycle: acceptance of an incoming beat, late or not, and delivery of a stored beat downstream. Either one can also move `up_ready`. The bench provokes this collision on purpose at the occupancy where one extra beat would drop ready. It then confirms that ready stays high and that the data order holds. Random traffic with a sender that honours the allowance repeats the collision thousands of times, and at every cycle the bench compares ready, valid, head data and the overflow flag against a queue model.

// File: rtl/sink_pkg.sv
package sink_pkg;

  // Free entries left in a buffer of the given depth.
  function automatic int free_slots(input int depth, input int occ);
    return depth - occ;
  endfunction

  // The receiver may advertise ready only if the current beat plus
  // every permitted late beat still fits.
  function automatic bit may_ready(input int free, input int allow);
    return free >= allow + 1;
  endfunction

  // Occupancy after one cycle of optional push and pop.
  function automatic int next_occ(input int occ, input bit push, input bit pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // Pointer advance with wrap for any depth.
  function automatic int wrap_inc(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/sink_store.sv
module sink_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CW-1:0]     occ
);
  import sink_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic              store_full;

  assign store_full = (int'(occ) == DEPTH);
  assign head_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= AW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(wrap_inc(int'(rd_ptr), DEPTH));
      occ <= CW'(next_occ(int'(occ), push, pop));
    end
  end

  // R4: the admission rule must never push into a full store
  a_r4_no_full_push: assert property (@(posedge clk) disable iff (rst)
    push |-> !store_full);

  // R2: nothing is taken from an empty store
  a_r2_no_empty_pop: assert property (@(posedge clk) disable iff (rst)
    pop |-> (occ != '0));

  // R7: a paired push and pop keeps occupancy
  a_r7_pair_stable: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(occ));

endmodule

// File: rtl/sink_admit.sv
module sink_admit #(
  parameter int DEPTH = 8,
  parameter int ALLOW = 2,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [CW-1:0] occ,
  input  logic          pop,
  output logic          in_ready,
  output logic          push,
  output logic          overflow
);
  import sink_pkg::*;

  localparam int LW = (ALLOW < 1) ? 1 : $clog2(ALLOW + 1);

  logic          ready_q;
  logic [LW-1:0] late_cnt;
  logic          late_beat;
  logic          late_room;
  logic          ovf_evt;
  logic          ready_d;
  int            occ_after;

  assign in_ready  = ready_q;
  assign late_beat = in_valid && !ready_q;
  assign late_room = int'(late_cnt) < ALLOW;
  assign push      = in_valid && (ready_q || late_room);
  assign ovf_evt   = late_beat && !late_room;
  assign occ_after = next_occ(int'(occ), push, pop);
  assign ready_d   = may_ready(free_slots(DEPTH, occ_after), ALLOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q  <= 1'b1;
      late_cnt <= '0;
      overflow <= 1'b0;
    end else begin
      ready_q <= ready_d;
      if (ready_d || ready_q)       late_cnt <= '0;
      else if (late_beat && push)   late_cnt <= late_cnt + 1'b1;
      if (ovf_evt)                  overflow <= 1'b1;
    end
  end

  // R3: ready is only shown while room for the allowance exists
  a_r3_ready_room: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> (free_slots(DEPTH, int'(occ)) >= ALLOW + 1));

  // R5: the late count never passes the allowance
  a_r5_late_cap: assert property (@(posedge clk) disable iff (rst)
    int'(late_cnt) <= ALLOW);

  // R5: a fresh low period starts from zero
  a_r5_clear_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> (late_cnt == '0));

  // R6: a beat beyond the allowance is not stored and raises the flag
  a_r6_drop: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |-> !push);
  a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> overflow);
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

endmodule

// File: rtl/stream_skid_sink.sv
module stream_skid_sink #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 8,
  parameter int LATENCY   = 2,
  parameter int ALLOWANCE = LATENCY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_valid,
  output logic              up_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              overflow
);
  localparam int CW = $clog2(DEPTH + 1);

  if (DEPTH < ALLOWANCE + 1) begin : g_depth_check
    $error("stream_skid_sink: DEPTH must exceed ALLOWANCE");
  end

  logic          push;
  logic          pop;
  logic [CW-1:0] occ;

  assign dn_valid = (occ != '0);
  assign pop      = dn_valid && dn_ready;

  sink_admit #(
    .DEPTH (DEPTH),
    .ALLOW (ALLOWANCE),
    .CW    (CW)
  ) u_admit (
    .clk      (clk),
    .rst      (rst),
    .in_valid (up_valid),
    .occ      (occ),
    .pop      (pop),
    .in_ready (up_ready),
    .push     (push),
    .overflow (overflow)
  );

  sink_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CW     (CW)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (up_data),
    .pop       (pop),
    .head_data (dn_data),
    .occ       (occ)
  );

  // R1: state right after reset
  a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (up_ready && !dn_valid && !overflow));

  // R8: a stalled head beat holds
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

endmodule

// File: tb/test_stream_skid_sink.sv
module test_stream_skid_sink;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int LAT   = 2;
  localparam int ALLOW = LAT;   // R9: the instance leaves ALLOWANCE unset

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;        // 50 MHz

  logic [DW-1:0] up_data = '0;
  logic          up_valid = 1'b0;
  logic          up_ready;
  logic [DW-1:0] dn_data;
  logic          dn_valid;
  logic          dn_ready = 1'b0;
  logic          overflow;

  logic [DW-1:0] z_data = '0;
  logic          z_valid = 1'b0;
  logic          z_ready;
  logic [DW-1:0] z_dn_data;
  logic          z_dn_valid;
  logic          z_dn_ready = 1'b0;
  logic          z_ovf;

  stream_skid_sink #(.DATA_W(DW), .DEPTH(DEPTH), .LATENCY(LAT)) i_stream_skid_sink (
    .clk(clk), .rst(rst), .up_data(up_data), .up_valid(up_valid), .up_ready(up_ready),
    .dn_data(dn_data), .dn_valid(dn_valid), .dn_ready(dn_ready), .overflow(overflow));

  stream_skid_sink #(.DATA_W(DW), .DEPTH(4), .LATENCY(0), .ALLOWANCE(0)) i_stream_skid_sink_zero (
    .clk(clk), .rst(rst), .up_data(z_data), .up_valid(z_valid), .up_ready(z_ready),
    .dn_data(z_dn_data), .dn_valid(z_dn_valid), .dn_ready(z_dn_ready), .overflow(z_ovf));

  int n_chk = 0;
  int n_bad = 0;
  int n_out = 0;
  logic [DW-1:0] q[$];
  bit m_ready;
  int m_late;
  bit m_ovf;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Room needed: the beat now plus every late beat.
  function automatic bit exp_ready(input int occ);
    return (DEPTH - occ) > ALLOW;
  endfunction

  task automatic compare();
    check(up_ready == m_ready, "R3 up_ready", int'(up_ready), int'(m_ready));
    check(dn_valid == (q.size() != 0), "R2 dn_valid", int'(dn_valid), int'(q.size() != 0));
    if (q.size() != 0)
      check(dn_data == q[0], "R2 head order", int'(dn_data), int'(q[0]));
    check(overflow == m_ovf, "R6 overflow", int'(overflow), int'(m_ovf));
  endtask

  // Drive at a falling edge, model the rising edge, compare at the next falling edge.
  task automatic step(input bit v, input logic [DW-1:0] d, input bit o);
    bit late, ok, pop, nr;
    up_valid = v; up_data = d; dn_ready = o;
    late = v && !m_ready;
    ok   = v && (m_ready || m_late < ALLOW);
    pop  = (q.size() != 0) && o;
    if (pop) begin void'(q.pop_front()); n_out++; end
    if (ok) q.push_back(d);
    if (late && !ok) m_ovf = 1'b1;
    nr = exp_ready(q.size());
    if (nr || m_ready) m_late = 0;
    else if (late && ok) m_late++;
    m_ready = nr;
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    up_valid = 1'b0; dn_ready = 1'b0; z_valid = 1'b0; z_dn_ready = 1'b0;
    repeat (3) @(negedge clk);
    q.delete(); m_ready = 1'b1; m_late = 0; m_ovf = 1'b0;
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    do_reset();
    // R1
    check(up_ready == 1'b1, "R1 reset ready", int'(up_ready), 1);
    check(dn_valid == 1'b0, "R1 reset empty", int'(dn_valid), 0);
    check(overflow == 1'b0, "R1 reset overflow", int'(overflow), 0);

    // R4 / R9: fill until ready drops, then two late beats with a gap
    for (int i = 0; i < 6; i++) step(1'b1, 8'(8'h10 + i), 1'b0);
    check(up_ready == 1'b0, "R3 ready low at occupancy 6", int'(up_ready), 0);
    step(1'b1, 8'h20, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    step(1'b1, 8'h21, 1'b0);
    check(overflow == 1'b0, "R4 spread late beats accepted", int'(overflow), 0);
    check(overflow == 1'b0, "R9 default allowance equals latency", int'(overflow), 0);
    base = n_out;
    for (int i = 0; i < 10; i++) step(1'b0, 8'h00, 1'b1);
    check(n_out - base == 8, "R4 all eight beats delivered", n_out - base, 8);

    // R5: one late beat, ready rises, then a new low period with two more
    for (int i = 0; i < 6; i++) step(1'b1, 8'(8'h30 + i), 1'b0);
    step(1'b1, 8'h3a, 1'b0);
    step(1'b0, 8'h00, 1'b1);
    step(1'b0, 8'h00, 1'b1);
    check(up_ready == 1'b1, "R5 ready back at occupancy 5", int'(up_ready), 1);
    step(1'b1, 8'h3b, 1'b0);
    step(1'b1, 8'h3c, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    step(1'b1, 8'h3d, 1'b0);
    check(overflow == 1'b0, "R5 allowance renewed", int'(overflow), 0);
    for (int i = 0; i < 10; i++) step(1'b0, 8'h00, 1'b1);

    // R7: at occupancy 5 a paired push and pop keeps ready high
    for (int i = 0; i < 5; i++) step(1'b1, 8'(8'h50 + i), 1'b0);
    step(1'b1, 8'h55, 1'b1);
    check(up_ready == 1'b1, "R7 paired transfer keeps ready", int'(up_ready), 1);
    check(dn_data == 8'h51, "R7 head advanced", int'(dn_data), 8'h51);
    // R8: stalled head holds
    step(1'b0, 8'h00, 1'b0);
    check(dn_data == 8'h51, "R8 stalled head holds", int'(dn_data), 8'h51);
    for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 1'b1);

    // Random traffic from a sender that honours the allowance
    for (int i = 0; i < 3000; i++) begin
      bit v;
      v = ($urandom % 2) == 0;
      if (!m_ready && m_late >= ALLOW) v = 1'b0;
      step(v, 8'($urandom), ($urandom % 10) < 6);
    end
    check(overflow == 1'b0, "R4 compliant sender never flagged", int'(overflow), 0);

    // R6: a sender that overruns the allowance
    for (int i = 0; i < 12; i++) step(1'b1, 8'(8'h80 + i), 1'b0);
    check(overflow == 1'b1, "R6 overrun flagged", int'(overflow), 1);
    for (int i = 0; i < 12; i++) step(1'b0, 8'h00, 1'b1);
    check(overflow == 1'b1, "R6 flag sticky", int'(overflow), 1);
    check(dn_valid == 1'b0, "R6 dropped beats not stored", int'(dn_valid), 0);

    // R10: zero allowance instance
    do_reset();
    check(z_ready == 1'b1, "R1 zero instance reset ready", int'(z_ready), 1);
    for (int i = 0; i < 4; i++) begin
      check(z_ready == 1'b1, "R3 zero instance ready", int'(z_ready), 1);
      z_valid = 1'b1; z_data = 8'(8'h40 + i);
      @(negedge clk);
    end
    check(z_ready == 1'b0, "R10 ready low when full", int'(z_ready), 0);
    check(z_ovf == 1'b0, "R10 no flag yet", int'(z_ovf), 0);
    z_data = 8'h99;
    @(negedge clk);
    z_valid = 1'b0;
    check(z_ovf == 1'b1, "R10 beat while low flagged", int'(z_ovf), 1);
    z_dn_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check(z_dn_valid == 1'b1, "R10 stored beat present", int'(z_dn_valid), 1);
      check(z_dn_data == 8'(8'h40 + i), "R10 order kept", int'(z_dn_data), 8'h40 + i);
      @(negedge clk);
    end
    check(z_dn_valid == 1'b0, "R10 late beat discarded", int'(z_dn_valid), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule